// File: doc/BRIEF.md
# Variable-Fanout Radix Page Table Walker

This block turns an effective address into a real address by walking a radix page table kept in memory. A request carries the address, the base of the root table, the index width of the root level and the size in bits of the address space the table covers. The walker reads one 64-bit entry per level through a memory read port with a request/response handshake. The width of each later level's index comes from the directory entry that points to it, so tables of different fanout can be mixed within one tree.

The number of address bits still to be resolved, called the remaining size, starts at the space size and drops by the index width of each level that is read. When a leaf is reached, the remaining size is the page size. The walker reports the real address, the page size, the leaf entry and the address it was read from. When a walk fails it reports a fault cause. Only one walk is active at a time.

Entry layout (64 bits): bit 63 valid, bit 62 leaf, bits [55:8] next table base (the low 8 bits are taken as zero), bits [4:0] next index width, bits [55:12] page number of a leaf. Fault cause codes: 2'b00 none, 2'b01 bad configuration, 2'b10 no valid entry.

Top module: `rw_radix_walker`

## Requirements
- R1: `req_ready` is high only while no walk is active. A `req_valid` seen while `req_ready` is low is ignored and does not change the walk in progress.
- R2: At each level the entry address is table base + 8 × ((address >> (remaining − index width)) masked to index-width bits).
- R3: If a level's index width is below 5 or above the remaining size, the walk ends with cause 2'b01 and that level is not read.
- R4: An entry with bit 63 clear ends the walk with cause 2'b10.
- R5: After each valid entry the remaining size drops by that level's index width. A directory entry (bit 62 clear) supplies the next base from bits [55:8] and the next index width from bits [4:0].
- R6: A leaf (bit 62 set) ends the walk with cause 2'b00. `done_psize` is the remaining size, and `done_pte` and `done_pte_addr` are the leaf and its address.
- R7: `done_raddr` equals (leaf & 0x00FF_FFFF_FFFF_F000) with its low `done_psize` bits cleared, ORed with those low bits of the input address.
- R8: A walk reads at most MAX_LEVELS entries. Needing one more read ends it with cause 2'b01.
- R9: `mem_req_valid` stays high with a stable address until `mem_req_ready`, and a walk has at most one read outstanding.
- R10: `done_valid` is a one-cycle pulse and never carries cause 2'b11.
- R11: After reset `req_ready` is 1 and both `mem_req_valid` and `done_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk |
| req_ready | output | 1 | Walker idle, request accepted |
| req_addr | input | 64 | Address to translate |
| req_root_base | input | 64 | Root table base |
| req_root_isize | input | 5 | Root index width |
| req_space_size | input | SIZE_W | Initial remaining size |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read |
| done_valid | output | 1 | Walk finished (one cycle) |
| done_cause | output | 2 | Fault cause |
| done_raddr | output | 64 | Translated real address |
| done_psize | output | SIZE_W | Page size in address bits |
| done_pte | output | 64 | Leaf entry |
| done_pte_addr | output | 64 | Address of the final entry read |

## Verification
The assertions check the port protocol on every cycle: a pending read is held until accepted, no read is issued while the walker is idle, completion pulses last one cycle, and no cause code is illegal. Address arithmetic, the shrinking remaining size, leaf composition, both fault paths and the depth bound can only be shown by the bench. It walks a three-level table with leaves at several depths and compares every result, and the number of reads each walk made, against a reference walk of its own.

// File: rtl/rw_pkg.sv
package rw_pkg;
  localparam int ENTRY_W   = 64;
  localparam int ISIZE_W   = 5;
  localparam int BIT_VALID = 63;
  localparam int BIT_LEAF  = 62;
  localparam logic [ENTRY_W-1:0] BASE_MASK = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [ENTRY_W-1:0] PAGE_MASK = 64'h00FF_FFFF_FFFF_F000;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_BADCFG = 2'b01,
    CAUSE_NOENT  = 2'b10
  } cause_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_REQ,
    ST_WAIT
  } walk_st_t;
endpackage

// File: rtl/rw_entry_addr.sv
module rw_entry_addr
  import rw_pkg::*;
#(
  parameter int SIZE_W = 7
) (
  input  logic [ENTRY_W-1:0] ea,
  input  logic [ENTRY_W-1:0] base,
  input  logic [SIZE_W-1:0]  rem,
  input  logic [ISIZE_W-1:0] isz,
  output logic [ENTRY_W-1:0] entry_addr
);
  logic [SIZE_W-1:0]  shamt;
  logic [ENTRY_W-1:0] idx_mask;
  logic [ENTRY_W-1:0] idx;

  always_comb begin
    shamt      = rem - SIZE_W'(isz);
    idx_mask   = (ENTRY_W'(1) << isz) - ENTRY_W'(1);
    idx        = (ea >> shamt) & idx_mask;
    entry_addr = base + (idx << 3);
  end
endmodule

// File: rtl/rw_leaf_compose.sv
module rw_leaf_compose
  import rw_pkg::*;
#(
  parameter int SIZE_W = 7
) (
  input  logic [ENTRY_W-1:0] ea,
  input  logic [ENTRY_W-1:0] pte,
  input  logic [SIZE_W-1:0]  psize,
  output logic [ENTRY_W-1:0] raddr
);
  logic [ENTRY_W-1:0] low_mask;

  always_comb begin
    if (psize >= SIZE_W'(ENTRY_W)) low_mask = '1;
    else                           low_mask = (ENTRY_W'(1) << psize) - ENTRY_W'(1);
    raddr = (pte & PAGE_MASK & ~low_mask) | (ea & low_mask);
  end
endmodule

// File: rtl/rw_radix_walker.sv
module rw_radix_walker
  import rw_pkg::*;
#(
  parameter int SIZE_W     = 7,
  parameter int MAX_LEVELS = 4,
  parameter int MIN_ISIZE  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [63:0]        req_addr,
  input  logic [63:0]        req_root_base,
  input  logic [4:0]         req_root_isize,
  input  logic [SIZE_W-1:0]  req_space_size,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [63:0]        mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [63:0]        mem_rsp_data,
  output logic               done_valid,
  output logic [1:0]         done_cause,
  output logic [63:0]        done_raddr,
  output logic [SIZE_W-1:0]  done_psize,
  output logic [63:0]        done_pte,
  output logic [63:0]        done_pte_addr
);
  localparam int LVL_W = $clog2(MAX_LEVELS + 1);

  walk_st_t           st_q;
  logic [ENTRY_W-1:0] ea_q, base_q;
  logic [ISIZE_W-1:0] isz_q;
  logic [SIZE_W-1:0]  rem_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [ENTRY_W-1:0] next_addr, leaf_raddr;
  logic [SIZE_W-1:0]  rem_after;
  logic               cfg_bad;

  assign req_ready = (st_q == ST_IDLE);
  assign rem_after = rem_q - SIZE_W'(isz_q);
  assign cfg_bad   = (isz_q < ISIZE_W'(MIN_ISIZE)) || (SIZE_W'(isz_q) > rem_q) ||
                     (lvl_q == LVL_W'(MAX_LEVELS));

  rw_entry_addr #(.SIZE_W(SIZE_W)) u_addr (
    .ea(ea_q), .base(base_q), .rem(rem_q), .isz(isz_q), .entry_addr(next_addr)
  );

  rw_leaf_compose #(.SIZE_W(SIZE_W)) u_leaf (
    .ea(ea_q), .pte(mem_rsp_data), .psize(rem_after), .raddr(leaf_raddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      ea_q          <= '0;
      base_q        <= '0;
      isz_q         <= '0;
      rem_q         <= '0;
      lvl_q         <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      done_valid    <= 1'b0;
      done_cause    <= CAUSE_NONE;
      done_raddr    <= '0;
      done_psize    <= '0;
      done_pte      <= '0;
      done_pte_addr <= '0;
    end else begin
      done_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            ea_q   <= req_addr;
            base_q <= req_root_base;
            isz_q  <= req_root_isize;
            rem_q  <= req_space_size;
            lvl_q  <= '0;
            st_q   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (cfg_bad) begin
            done_valid <= 1'b1;
            done_cause <= CAUSE_BADCFG;
            st_q       <= ST_IDLE;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_addr  <= next_addr;
            st_q          <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            st_q          <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            lvl_q <= lvl_q + LVL_W'(1);
            if (!mem_rsp_data[BIT_VALID]) begin
              done_valid    <= 1'b1;
              done_cause    <= CAUSE_NOENT;
              done_pte_addr <= mem_req_addr;
              st_q          <= ST_IDLE;
            end else if (mem_rsp_data[BIT_LEAF]) begin
              done_valid    <= 1'b1;
              done_cause    <= CAUSE_NONE;
              done_raddr    <= leaf_raddr;
              done_psize    <= rem_after;
              done_pte      <= mem_rsp_data;
              done_pte_addr <= mem_req_addr;
              st_q          <= ST_IDLE;
            end else begin
              rem_q  <= rem_after;
              base_q <= mem_rsp_data & BASE_MASK;
              isz_q  <= mem_rsp_data[ISIZE_W-1:0];
              st_q   <= ST_CHECK;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rw_radix_walker_chk.sv
module rw_radix_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        done_valid,
  input logic [1:0]  done_cause
);
  assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_no_read_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && mem_req_valid));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  assert_cause_legal_R10: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (done_cause != 2'b11));

  assert_done_only_idle_R1: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> req_ready);
endmodule

bind rw_radix_walker rw_radix_walker_chk u_chk (.*);

// File: tb/tb_rw_radix_walker.sv
module tb_rw_radix_walker;
  localparam int SIZE_W = 7;
  localparam int MAXL   = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [63:0] req_addr = '0, req_root_base = '0, mem_rsp_data = '0;
  logic [4:0] req_root_isize = '0;
  logic [SIZE_W-1:0] req_space_size = '0;
  logic req_ready, mem_req_valid, done_valid;
  logic [63:0] mem_req_addr, done_raddr, done_pte, done_pte_addr;
  logic [1:0] done_cause;
  logic [SIZE_W-1:0] done_psize;

  logic [63:0] mem [0:1023];
  logic        hs_pend = 1'b0;
  logic [63:0] hs_addr = '0;
  int          nreads = 0;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  rw_radix_walker #(.SIZE_W(SIZE_W), .MAX_LEVELS(MAXL)) dut (.*);

  // memory responder: randomly stalls requests, answers one cycle after acceptance
  always @(negedge clk) begin
    if (hs_pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem[hs_addr[12:3]];
      hs_pend       = 1'b0;
    end else begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = {$urandom, $urandom};
    end
    mem_req_ready = ($urandom % 2) == 0;
    if (mem_req_valid && mem_req_ready) begin
      hs_pend = 1'b1;
      hs_addr = mem_req_addr;
      nreads++;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    finish_run();
  end

  function automatic logic [63:0] mk_leaf();
    return 64'hC000_0000_0000_0000 | ({$urandom, $urandom} & 64'h00FF_FFFF_FFFF_F000);
  endfunction

  function automatic logic [63:0] mk_dir(input logic [63:0] base, input int isz);
    return 64'h8000_0000_0000_0000 | (base & 64'h00FF_FFFF_FFFF_FF00) | 64'(isz);
  endfunction

  // reference walk from the requirements
  task automatic ref_walk(input logic [63:0] a, input logic [63:0] rb, input int ri, input int sp,
                          output logic [1:0] cause, output logic [63:0] ra, output int ps,
                          output logic [63:0] pte, output logic [63:0] pa, output int reads);
    int rem = sp, isz = ri, lvl = 0;
    logic [63:0] base = rb, idx, e, m;
    cause = 2'b00; ra = '0; ps = 0; pte = '0; pa = '0; reads = 0;
    forever begin
      if (isz < 5 || isz > rem || lvl == MAXL) begin cause = 2'b01; return; end
      idx = (a >> (rem - isz)) & ((64'd1 << isz) - 64'd1);
      pa = base + idx * 8;
      e = mem[pa[12:3]];
      lvl++; reads = lvl;
      if (!e[63]) begin cause = 2'b10; return; end
      rem -= isz;
      if (e[62]) begin
        ps = rem; pte = e;
        m = (rem >= 64) ? '1 : ((64'd1 << rem) - 64'd1);
        ra = (e & 64'h00FF_FFFF_FFFF_F000 & ~m) | (a & m);
        return;
      end
      base = e & 64'h00FF_FFFF_FFFF_FF00;
      isz = int'(e[4:0]);
    end
  endtask

  task automatic walk(input logic [63:0] a, input logic [63:0] rb, input int ri, input int sp,
                      input bit poke_busy, input string tag);
    logic [1:0] c; logic [63:0] ra, pte, pa; int ps, rd, t;
    ref_walk(a, rb, ri, sp, c, ra, ps, pte, pa, rd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_root_base = rb;
    req_root_isize = 5'(ri); req_space_size = SIZE_W'(sp);
    nreads = 0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, {tag, " R1 busy after accept"}, 64'(req_ready), 64'd0);
    if (poke_busy) begin
      // R1: a request while busy must be ignored
      req_valid = 1'b1; req_addr = ~a; req_root_isize = 5'd4; req_space_size = SIZE_W'(3);
      @(negedge clk);
      req_valid = 1'b0;
    end
    t = 0;
    while (!done_valid && t < 2000) begin @(negedge clk); t++; end
    chk(done_cause == c, {tag, " R3/R4/R8 cause"}, 64'(done_cause), 64'(c));
    chk(nreads == rd, {tag, " R2/R8/R9 read count"}, 64'(nreads), 64'(rd));
    if (c == 2'b00) begin
      chk(done_psize == SIZE_W'(ps), {tag, " R5 psize"}, 64'(done_psize), 64'(ps));
      chk(done_raddr == ra, {tag, " R7 raddr"}, done_raddr, ra);
      chk(done_pte == pte && done_pte_addr == pa, {tag, " R6/R2 leaf"}, done_pte_addr, pa);
    end
    @(negedge clk);
    chk(done_valid == 1'b0, {tag, " R10 pulse"}, 64'(done_valid), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd7021));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    // root at 0x000, 32 entries
    for (int i = 0; i < 32; i++)
      case (i % 4)
        0: mem[i] = 64'd0;
        1: mem[i] = mk_leaf();
        2: mem[i] = mk_dir(64'h400, 5);
        default: mem[i] = mk_dir(64'h800, 3);
      endcase
    // level-two table at 0x400
    for (int j = 0; j < 32; j++)
      case (j % 3)
        0: mem[128 + j] = mk_leaf();
        1: mem[128 + j] = 64'd0;
        default: mem[128 + j] = mk_dir(64'h600, 5);
      endcase
    // level-three table at 0x600
    for (int j = 0; j < 32; j++)
      mem[192 + j] = (j == 7) ? mk_dir(64'h400, 5) : mk_leaf();

    repeat (3) @(negedge clk);
    chk(req_ready == 1 && mem_req_valid == 0 && done_valid == 0, "R11 reset state",
        {61'd0, req_ready, mem_req_valid, done_valid}, 64'h4);
    rst = 1'b0;

    walk(64'h0, 64'h0, 4, 20, 0, "R3 small root width");
    walk(64'h0, 64'h0, 6, 5, 0, "R3 width above remaining");
    walk(64'h0, 64'h0, 5, 20, 0, "R4 invalid root");
    walk(64'h0000_0000_0000_8ABC, 64'h0, 5, 20, 0, "R6 leaf at level one");
    walk((64'd2 << 15) | (64'd0 << 10) | 64'h3FF, 64'h0, 5, 20, 1, "R1 busy poke two-level");
    walk((64'd2 << 15) | (64'd2 << 10) | (64'd9 << 5) | 64'h1F, 64'h0, 5, 20, 0, "R5 three-level");
    walk((64'd2 << 15) | (64'd1 << 10), 64'h0, 5, 20, 0, "R4 invalid level two");
    walk((64'd3 << 15), 64'h0, 5, 20, 0, "R3 child width 3");
    walk((64'd2 << 55) | (64'd2 << 50) | (64'd7 << 45) | (64'd2 << 40), 64'h0, 5, 60, 0, "R8 depth");
    walk((64'd1 << 59) | 64'hFFF_FFFF_FFFF_FFFF, 64'h0, 5, 64, 0, "R7 full space");

    for (int k = 0; k < 150; k++) begin
      int sp;
      case ($urandom % 4)
        0: sp = 20;
        1: sp = 30;
        2: sp = 45;
        default: sp = 60;
      endcase
      walk({$urandom, $urandom}, 64'h0, 5, sp, (k % 10) == 0, "R2 random");
    end
    finish_run();
  end
endmodule